// File: doc/BRIEF.md
# Interleaved Bitstream Section Extractor

The block sits at the front of a configuration loader. Its byte input carries several configuration images woven together in equal fixed-size chunks: chunk 0 of every image in order, then chunk 1 of every image, and so on. A start pulse arms the block and latches a 1-based image index. From then on the block accepts every incoming byte. It counts each one and throws away the bytes that belong to other images. The bytes of the chosen image go to a header parser.

The parser first checks a fixed 13-byte signature. It then walks a list of typed sections, each with a big-endian length, and skips the content of every section that is not wanted. The search is bounded by a fixed number of header bytes. When the payload section turns up, the block raises `found`, shows the 32-bit payload length and streams exactly that many payload bytes through a valid/ready output. Back-pressure on the output stalls the input only while a byte of the chosen image is waiting. A bad signature, an unknown section type, an oversized short section or an exhausted search raises `error` instead.

Top module: `ilv_section_extract`

## Requirements
- R1: After reset and before any start pulse, `in_ready`, `found`, `error` and `out_valid` are all 0.
- R2: A start pulse clears the byte counter, the parser state, `found` and `error`, and latches `img_sel`. A second run after an earlier one therefore parses the new stream from its first byte.
- R3: With CHUNK_BYTES = 288 and N images, an accepted byte belongs to the chosen image when (bytes accepted since start / 288) mod N equals `img_sel` − 1.
- R4: Bytes of other images are accepted (in_ready high) and never appear on the output, and they advance the byte count.
- R5: The chosen image must open with 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. The first differing byte raises `error`.
- R6: Each section is a type byte followed by a big-endian length. The length takes 4 bytes for type 0x65 ('e') and 2 bytes for any other type.
- R7: A type byte below 0x61 or above 0x65 raises `error`.
- R8: A section of a type other than 0x65 with a length above 255 raises `error`.
- R9: The content bytes of sections other than 0x65 are consumed and discarded.
- R10: Header bytes after the signature are counted: type, length and skipped content bytes. If the count has reached 100 when a new type byte or another skipped byte is due, `error` is raised.
- R11: On a 0x65 section, `found` rises, `pay_len` shows its length, and exactly that many following bytes of the chosen image go out on `out_data`. `in_ready` then stays 0. `found` and `error` are never both 1.
- R12: `error` holds until the next start. While it is set, `out_valid` is 0 and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that arms a new extraction |
| img_sel | input | SEL_W | 1-based index of the image to keep, latched at start |
| in_data | input | 8 | Interleaved stream byte |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte taken this cycle when valid |
| found | output | 1 | Payload section located |
| error | output | 1 | Extraction failed |
| pay_len | output | 32 | Payload length, meaningful while found is 1 |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | Payload byte present |
| out_ready | input | 1 | Downstream takes the payload byte |

## Verification
Two things can land on the same cycle: the chunk counter wrapping to another image, and the parser streaming a payload byte under output back-pressure. The bench provokes this with a 300-byte payload in the second image. The payload runs past a 288-byte chunk edge while `out_ready` is held low on one cycle in three. The run passes if every payload byte arrives in order, none of the first image's bytes slip into the output, and the reported length matches.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   localparam int MAGIC_LEN       = 13;
   localparam int LONG_LEN_BYTES  = 4;
   localparam int SHORT_LEN_BYTES = 2;
   localparam int PAY_LEN_W       = 8 * LONG_LEN_BYTES;

   localparam logic [7:0] TYPE_FIRST  = 8'h61;
   localparam logic [7:0] TYPE_LAST   = 8'h65;
   localparam logic [7:0] TYPE_TARGET = 8'h65;
   localparam logic [7:0] TYPE_LONG   = 8'h65;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MAGIC,
      ST_TYPE,
      ST_LEN,
      ST_SKIP,
      ST_PAY,
      ST_DONE,
      ST_ERR
   } prs_state_t;

   function automatic logic [7:0] magic_byte(input logic [3:0] idx);
      logic [7:0] b;
      case (idx)
         4'd0:    b = 8'h00;
         4'd1:    b = 8'h09;
         4'd10:   b = 8'h00;
         4'd11:   b = 8'h00;
         4'd12:   b = 8'h01;
         default: b = idx[0] ? 8'hF0 : 8'h0F;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/ilv_chunk_filter.sv
module ilv_chunk_filter #(
   parameter int CHUNK_BYTES = 288,
   parameter int NUM_IMAGES  = 2,
   parameter int SEL_W       = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEL_W-1:0] img_sel,
   input  logic             advance,
   output logic             is_sel
);

   localparam int POS_W = (CHUNK_BYTES > 1) ? $clog2(CHUNK_BYTES) : 1;
   localparam int IDX_W = (NUM_IMAGES > 1) ? $clog2(NUM_IMAGES) : 1;
   localparam logic [POS_W-1:0] POS_LAST = POS_W'(CHUNK_BYTES - 1);

   initial begin
      assert (CHUNK_BYTES >= 2) else $error("CHUNK_BYTES must be at least 2");
      assert (NUM_IMAGES >= 1) else $error("NUM_IMAGES must be at least 1");
      assert (SEL_W >= $clog2(NUM_IMAGES + 1)) else $error("SEL_W too narrow");
   end

   logic [POS_W-1:0] pos_q;
   logic             chunk_end;

   assign chunk_end = (pos_q == POS_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (start) begin
         pos_q <= '0;
      end else if (advance) begin
         pos_q <= chunk_end ? '0 : pos_q + 1'b1;
      end
   end

   generate
      if (NUM_IMAGES == 1) begin : g_single
         assign is_sel = 1'b1;
      end else begin : g_multi
         localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_IMAGES - 1);
         logic [IDX_W-1:0] idx_q;
         logic [IDX_W-1:0] want_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx_q  <= '0;
               want_q <= '0;
            end else if (start) begin
               idx_q  <= '0;
               want_q <= IDX_W'(img_sel - 1'b1);
            end else if (advance && chunk_end) begin
               idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
            end
         end

         assign is_sel = (idx_q == want_q);

         p_owner_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
            advance && chunk_end && !start |=> idx_q != $past(idx_q));
      end
   endgenerate

   p_chunk_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      advance && chunk_end && !start |=> pos_q == '0);

   p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !advance && !start |=> $stable(pos_q));

endmodule

// File: rtl/ilv_hdr_parser.sv
module ilv_hdr_parser
   import ilv_pkg::*;
#(
   parameter int SEARCH_LIMIT = 100,
   parameter int SHORT_MAX    = 255
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 b_valid,
   input  logic [7:0]           b_data,
   output logic                 b_ready,
   input  logic                 out_ready,
   output logic                 out_valid,
   output logic [7:0]           out_data,
   output logic                 busy,
   output logic                 found,
   output logic                 error,
   output logic [PAY_LEN_W-1:0] pay_len
);

   localparam int CNT_W  = $clog2(SEARCH_LIMIT + LONG_LEN_BYTES + 2);
   localparam int SKIP_W = $clog2(SHORT_MAX + 1);
   localparam int MC_W   = $clog2(MAGIC_LEN);
   localparam int LL_W   = $clog2(LONG_LEN_BYTES);

   initial begin
      assert (SEARCH_LIMIT >= 1) else $error("SEARCH_LIMIT must be positive");
      assert (SHORT_MAX >= 1 && SHORT_MAX < 65536) else $error("SHORT_MAX out of range");
      assert (MC_W <= 4) else $error("signature table index too wide");
   end

   prs_state_t           state_q;
   logic [MC_W-1:0]      mcnt_q;
   logic [CNT_W-1:0]     hdr_cnt_q;
   logic [LL_W-1:0]      len_left_q;
   logic [7:0]           sec_type_q;
   logic [PAY_LEN_W-1:0] len_acc_q;
   logic [SKIP_W-1:0]    skip_left_q;
   logic [PAY_LEN_W-1:0] pay_left_q;

   logic                 take;
   logic                 limit_hit;
   logic                 type_ok;
   logic [PAY_LEN_W-1:0] len_next;
   logic [7:0]           magic_exp;

   assign limit_hit = (hdr_cnt_q >= CNT_W'(SEARCH_LIMIT));
   assign type_ok   = (b_data >= TYPE_FIRST) && (b_data <= TYPE_LAST);
   assign len_next  = {len_acc_q[PAY_LEN_W-9:0], b_data};
   assign magic_exp = magic_byte(4'(mcnt_q));

   always_comb begin
      b_ready = 1'b0;
      case (state_q)
         ST_MAGIC, ST_LEN: b_ready = 1'b1;
         ST_TYPE, ST_SKIP: b_ready = !limit_hit;
         ST_PAY:           b_ready = out_ready;
         default:          b_ready = 1'b0;
      endcase
   end

   assign take      = b_valid && b_ready;
   assign out_valid = (state_q == ST_PAY) && b_valid;
   assign out_data  = b_data;
   assign busy      = (state_q == ST_MAGIC) || (state_q == ST_TYPE) || (state_q == ST_LEN) ||
                      (state_q == ST_SKIP)  || (state_q == ST_PAY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         mcnt_q      <= '0;
         hdr_cnt_q   <= '0;
         len_left_q  <= '0;
         sec_type_q  <= '0;
         len_acc_q   <= '0;
         skip_left_q <= '0;
         pay_left_q  <= '0;
         found       <= 1'b0;
         error       <= 1'b0;
         pay_len     <= '0;
      end else if (start) begin
         state_q     <= ST_MAGIC;
         mcnt_q      <= '0;
         hdr_cnt_q   <= '0;
         len_left_q  <= '0;
         sec_type_q  <= '0;
         len_acc_q   <= '0;
         skip_left_q <= '0;
         pay_left_q  <= '0;
         found       <= 1'b0;
         error       <= 1'b0;
         pay_len     <= '0;
      end else begin
         case (state_q)
            ST_MAGIC: if (take) begin
               if (b_data != magic_exp) begin
                  state_q <= ST_ERR;
                  error   <= 1'b1;
               end else if (mcnt_q == MC_W'(MAGIC_LEN - 1)) begin
                  state_q <= ST_TYPE;
               end else begin
                  mcnt_q <= mcnt_q + 1'b1;
               end
            end
            ST_TYPE: begin
               if (limit_hit) begin
                  state_q <= ST_ERR;
                  error   <= 1'b1;
               end else if (take) begin
                  hdr_cnt_q <= hdr_cnt_q + 1'b1;
                  if (!type_ok) begin
                     state_q <= ST_ERR;
                     error   <= 1'b1;
                  end else begin
                     sec_type_q <= b_data;
                     len_acc_q  <= '0;
                     len_left_q <= (b_data == TYPE_LONG) ? LL_W'(LONG_LEN_BYTES - 1)
                                                         : LL_W'(SHORT_LEN_BYTES - 1);
                     state_q    <= ST_LEN;
                  end
               end
            end
            ST_LEN: if (take) begin
               hdr_cnt_q <= hdr_cnt_q + 1'b1;
               len_acc_q <= len_next;
               if (len_left_q != '0) begin
                  len_left_q <= len_left_q - 1'b1;
               end else if (sec_type_q == TYPE_TARGET) begin
                  found      <= 1'b1;
                  pay_len    <= len_next;
                  pay_left_q <= len_next;
                  state_q    <= (len_next == '0) ? ST_DONE : ST_PAY;
               end else if (len_next > PAY_LEN_W'(SHORT_MAX)) begin
                  state_q <= ST_ERR;
                  error   <= 1'b1;
               end else if (len_next == '0) begin
                  state_q <= ST_TYPE;
               end else begin
                  skip_left_q <= len_next[SKIP_W-1:0];
                  state_q     <= ST_SKIP;
               end
            end
            ST_SKIP: begin
               if (limit_hit) begin
                  state_q <= ST_ERR;
                  error   <= 1'b1;
               end else if (take) begin
                  hdr_cnt_q   <= hdr_cnt_q + 1'b1;
                  skip_left_q <= skip_left_q - 1'b1;
                  if (skip_left_q == SKIP_W'(1)) state_q <= ST_TYPE;
               end
            end
            ST_PAY: if (take) begin
               pay_left_q <= pay_left_q - 1'b1;
               if (pay_left_q == PAY_LEN_W'(1)) state_q <= ST_DONE;
            end
            default: state_q <= state_q;
         endcase
      end
   end

   p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      error && !start |=> error);

   p_err_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !out_valid && !b_ready);

   p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(found && error));

   p_len_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      found && !start |=> found && $stable(pay_len));

   p_bad_magic_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_MAGIC && take && b_data != magic_exp && !start |=> error);

   p_search_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TYPE || state_q == ST_SKIP) && limit_hit && !start |=> error);

   p_short_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_SKIP |-> skip_left_q != '0);

endmodule

// File: rtl/ilv_section_extract.sv
module ilv_section_extract
   import ilv_pkg::*;
#(
   parameter int CHUNK_BYTES  = 288,
   parameter int NUM_IMAGES   = 2,
   parameter int SEARCH_LIMIT = 100,
   parameter int SHORT_MAX    = 255,
   parameter int SEL_W        = $clog2(NUM_IMAGES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [SEL_W-1:0]     img_sel,
   input  logic [7:0]           in_data,
   input  logic                 in_valid,
   output logic                 in_ready,
   output logic                 found,
   output logic                 error,
   output logic [PAY_LEN_W-1:0] pay_len,
   output logic [7:0]           out_data,
   output logic                 out_valid,
   input  logic                 out_ready
);

   logic is_sel;
   logic busy;
   logic b_valid;
   logic b_ready;
   logic advance;

   assign b_valid  = in_valid && is_sel && busy;
   assign in_ready = busy && (is_sel ? b_ready : 1'b1);
   assign advance  = in_valid && in_ready;

   ilv_chunk_filter #(
      .CHUNK_BYTES (CHUNK_BYTES),
      .NUM_IMAGES  (NUM_IMAGES),
      .SEL_W       (SEL_W)
   ) i_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .img_sel (img_sel),
      .advance (advance),
      .is_sel  (is_sel)
   );

   ilv_hdr_parser #(
      .SEARCH_LIMIT (SEARCH_LIMIT),
      .SHORT_MAX    (SHORT_MAX)
   ) i_parser (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .b_valid   (b_valid),
      .b_data    (in_data),
      .b_ready   (b_ready),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .busy      (busy),
      .found     (found),
      .error     (error),
      .pay_len   (pay_len)
   );

   p_idle_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !in_ready && !out_valid);

   p_drop_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !is_sel |-> !out_valid);

   p_drop_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !is_sel |-> in_ready);

endmodule

// File: tb/test_ilv_section_extract.sv
module test_ilv_section_extract;

   localparam int CHUNK = 288;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  img_sel = 2'd1;
   logic [7:0]  in_data = 8'h00;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        found;
   logic        error;
   logic [31:0] pay_len;
   logic [7:0]  out_data;
   logic        out_valid;
   logic        out_ready = 1'b1;

   int total = 0;
   int bad   = 0;
   int err_out = 0;

   logic [7:0] wq[$];
   logic [7:0] epay[$];
   logic [7:0] img_a[$];
   logic [7:0] img_b[$];
   logic [7:0] expq[$];
   logic [7:0] comb[$];
   logic [7:0] got[$];

   always #4 clk = ~clk;

   ilv_section_extract i_ilv_section_extract (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .img_sel   (img_sel),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .found     (found),
      .error     (error),
      .pay_len   (pay_len),
      .out_data  (out_data),
      .out_valid (out_valid),
      .out_ready (out_ready)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put_magic(input int bad_at);
      logic [7:0] m[13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                            8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
      wq.delete();
      epay.delete();
      for (int i = 0; i < 13; i++) wq.push_back((i == bad_at) ? (m[i] ^ 8'h40) : m[i]);
   endtask

   task automatic put_sec(input logic [7:0] t, input int len, input int fill_n);
      wq.push_back(t);
      wq.push_back(8'(len >> 8));
      wq.push_back(8'(len));
      for (int i = 0; i < fill_n; i++) wq.push_back(8'hC3);
   endtask

   task automatic put_e(input int len, input logic [7:0] seed);
      wq.push_back(8'h65);
      wq.push_back(8'(len >> 24));
      wq.push_back(8'(len >> 16));
      wq.push_back(8'(len >> 8));
      wq.push_back(8'(len));
      for (int i = 0; i < len; i++) begin
         wq.push_back(8'(seed + 8'(i * 7)));
         epay.push_back(8'(seed + 8'(i * 7)));
      end
   endtask

   task automatic run(input int sel, input bit throttle);
      int n_chunks;
      int idx;
      int idle;
      int cyc;
      bit hs;
      comb.delete();
      got.delete();
      err_out = 0;
      n_chunks = ((img_a.size() > img_b.size() ? img_a.size() : img_b.size()) + CHUNK - 1) / CHUNK;
      for (int k = 0; k < n_chunks; k++) begin
         for (int i = 0; i < CHUNK; i++)
            comb.push_back((k * CHUNK + i < img_a.size()) ? img_a[k * CHUNK + i] : 8'h5A);
         for (int i = 0; i < CHUNK; i++)
            comb.push_back((k * CHUNK + i < img_b.size()) ? img_b[k * CHUNK + i] : 8'h5A);
      end
      @(negedge clk);
      img_sel = 2'(sel);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      idx = 0;
      idle = 0;
      cyc = 0;
      while (idx < comb.size() && idle < 6) begin
         in_valid  = 1'b1;
         in_data   = comb[idx];
         out_ready = throttle ? (cyc % 3 != 0) : 1'b1;
         #2;
         if (out_valid && out_ready) got.push_back(out_data);
         if (out_valid && error) err_out++;
         hs = in_ready;
         @(negedge clk);
         cyc++;
         if (hs) begin
            idx++;
            idle = 0;
         end else begin
            idle++;
         end
      end
      in_valid  = 1'b0;
      out_ready = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic cmp_payload(input string req);
      int mism = 0;
      chk(req, "payload byte count", 32'(got.size()), 32'(expq.size()));
      for (int i = 0; i < got.size() && i < expq.size(); i++)
         if (got[i] !== expq[i]) mism++;
      chk(req, "payload mismatches", 32'(mism), 32'd0);
   endtask

   task automatic t_reset();
      #1;
      chk("R1", "in_ready idle", 32'(in_ready), 32'd0);
      chk("R1", "found idle", 32'(found), 32'd0);
      chk("R1", "error idle", 32'(error), 32'd0);
      chk("R1", "out_valid idle", 32'(out_valid), 32'd0);
   endtask

   task automatic t_first_image();
      put_magic(-1); put_sec(8'h61, 3, 3); put_sec(8'h62, 2, 2); put_e(5, 8'h10);
      img_a = wq; expq = epay;
      put_magic(-1); put_e(4, 8'h80);
      img_b = wq;
      run(1, 1'b0);
      chk("R11", "found image 1", 32'(found), 32'd1);
      chk("R6", "length image 1", pay_len, 32'd5);
      chk("R9", "error image 1", 32'(error), 32'd0);
      cmp_payload("R3");
      chk("R11", "in_ready after payload", 32'(in_ready), 32'd0);
   endtask

   task automatic t_second_image_throttled();
      put_magic(-1); put_e(20, 8'h33);
      img_a = wq;
      put_magic(-1); put_sec(8'h64, 7, 7); put_e(300, 8'h41);
      img_b = wq; expq = epay;
      run(2, 1'b1);
      chk("R3", "found image 2", 32'(found), 32'd1);
      chk("R6", "big-endian length 0x12C", pay_len, 32'd300);
      cmp_payload("R4");
   endtask

   task automatic t_bad_magic();
      put_magic(5); put_e(4, 8'h11);
      img_a = wq;
      put_magic(-1); put_e(4, 8'h22);
      img_b = wq;
      run(1, 1'b0);
      chk("R5", "error on signature", 32'(error), 32'd1);
      chk("R5", "found on signature", 32'(found), 32'd0);
      chk("R12", "bytes after error", 32'(got.size()), 32'd0);
      chk("R12", "out_valid with error", 32'(err_out), 32'd0);
      repeat (5) @(negedge clk);
      chk("R12", "error held", 32'(error), 32'd1);
      chk("R12", "in_ready with error", 32'(in_ready), 32'd0);
   endtask

   task automatic t_bad_type();
      put_magic(-1); put_sec(8'h61, 1, 1); put_sec(8'h66, 1, 1); put_e(3, 8'h01);
      img_a = wq; img_b = wq;
      run(1, 1'b0);
      chk("R7", "error on type 0x66", 32'(error), 32'd1);
      put_magic(-1); put_sec(8'h60, 1, 1); put_e(3, 8'h01);
      img_a = wq;
      run(1, 1'b0);
      chk("R7", "error on type 0x60", 32'(error), 32'd1);
      chk("R7", "no payload on bad type", 32'(got.size()), 32'd0);
   endtask

   task automatic t_long_short();
      put_magic(-1); put_sec(8'h63, 256, 0); put_e(3, 8'h01);
      img_a = wq; img_b = wq;
      run(1, 1'b0);
      chk("R8", "error on short length 256", 32'(error), 32'd1);
      chk("R8", "found on short length 256", 32'(found), 32'd0);
   endtask

   task automatic t_limit();
      put_magic(-1); put_sec(8'h61, 40, 40); put_sec(8'h62, 40, 40); put_sec(8'h63, 10, 10); put_e(6, 8'h90);
      img_a = wq; expq = epay;
      img_b = wq;
      run(2, 1'b0);
      chk("R10", "found at 99 header bytes", 32'(found), 32'd1);
      cmp_payload("R10");
      put_magic(-1); put_sec(8'h61, 40, 40); put_sec(8'h62, 40, 40); put_sec(8'h63, 11, 11); put_e(6, 8'h90);
      img_b = wq;
      run(2, 1'b0);
      chk("R10", "error at 100 header bytes", 32'(error), 32'd1);
      chk("R10", "no payload past limit", 32'(got.size()), 32'd0);
   endtask

   task automatic t_zero_and_restart();
      put_magic(3); put_e(2, 8'h00);
      img_a = wq; img_b = wq;
      run(1, 1'b0);
      chk("R2", "error before restart", 32'(error), 32'd1);
      put_magic(-1); put_sec(8'h62, 0, 0); put_e(0, 8'h00);
      img_a = wq;
      run(1, 1'b0);
      chk("R2", "error cleared by start", 32'(error), 32'd0);
      chk("R6", "found zero length", 32'(found), 32'd1);
      chk("R6", "zero length value", pay_len, 32'd0);
      chk("R11", "no bytes for zero length", 32'(got.size()), 32'd0);
   endtask

   initial begin
      #(8 * 150000);
      bad++;
      total++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_first_image();
      t_second_image_throttled();
      t_bad_magic();
      t_bad_type();
      t_long_short();
      t_limit();
      t_zero_and_restart();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule